// File: doc/BRIEF.md
# Conversion Frame Resynchronizer

This block sets the frame timing of a sampling converter. A frame counter advances on master clock cycles while the conversion engine runs. Each time it reaches the programmed sample period it drives an active-low data-ready strobe. The strobe's falling edge marks the end of a conversion. A conversion-enable output tells the downstream modulator and filter logic when to advance. A pause flag shows when that logic is frozen.

Several converters may come out of reset at different times. They are brought into lockstep by pulling one shared sync line low. Each block measures how many master clock cycles separate its own latest strobe from the sync edge. It then finishes the conversion in progress and stalls for exactly that many cycles. After the stall, its frames line up with the sync edge. The frame is never restarted: the stall is the only correction applied.

The sync line is asynchronous. It passes through a multi-flop synchronizer, and the offset measurement subtracts the synchronizer's fixed latency. The period input is latched at every strobe, and any value below a minimum is raised to that minimum.

Top module: `frame_resync`

## Requirements
- R1: While reset is high and in the cycle after it is released, drdy_n_o is 1, conv_en_o is 1 and pause_o is 0. The first falling edge of drdy_n_o comes exactly P clock edges after the last edge that sampled reset high.
- R2: With no sync activity, drdy_n_o falls once every P clock edges and stays low for DRDY_LOW cycles (4 by default), after which it returns high.
- R3: period_i is latched at every drdy_n_o falling edge and governs the next frame only. A value below MIN_PERIOD (16 by default) is used as MIN_PERIOD.
- R4: Only a high-to-low transition of sync_n_i acts. Holding it low and raising it leave the strobe spacing and pause_o unchanged.
- R5: The first drdy_n_o fall after an accepted sync edge still comes exactly P edges after the previous fall: the running conversion is completed.
- R6: The offset O is the number of edges from the drdy_n_o fall to the first edge that samples sync_n_i low. After the frame in progress ends, pause_o is high and conv_en_o low for exactly O cycles, and the next fall comes P+O edges after the previous one.
- R7: After the delayed strobe, falls return to a spacing of P with no further pause.
- R8: A sync edge sampled on the same edge on which drdy_n_o falls gives O = 0: there is no pause and the spacing stays P.
- R9: A sync falling edge that arrives while a pause is pending or running is ignored. The pause length and all later strobes are those of the first edge alone.
- R10: conv_en_o is low exactly while pause_o is high. No drdy_n_o fall occurs after the first pause cycle.
- R11: A sync edge sampled one edge before a strobe, so that it is detected only after that strobe, is measured against the frame that just ended. It gives O = P-1 and delays the very next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n_i | input | 1 | Asynchronous sync line; its falling edge requests realignment |
| period_i | input | PERIOD_W | Sample period in master clock cycles |
| drdy_n_o | output | 1 | Active-low data-ready strobe; its falling edge ends a frame |
| conv_en_o | output | 1 | High while the conversion engine may advance |
| pause_o | output | 1 | High while the engine is stalled for realignment |

## Verification
The bench sweeps the sync edge across every cycle offset of a frame at two period settings and computes each expected strobe time by arithmetic. The sweep includes the edge that lands on the strobe itself, where a design that forgot the zero case would stall for a full period. It also includes the edge one cycle before the strobe, where a design that ignored synchronizer latency would measure against the wrong strobe and delay the wrong frame. Second sync edges are fired both while a pause is armed and while it runs; a design that re-armed would show a changed pause length or a second delay. Period changes and sub-minimum periods are checked for taking effect only at the next frame and for clamping.

// File: rtl/frs_pkg.sv
package frs_pkg;

    // Phase controller state: idle, waiting for the current frame to end,
    // or stalling the conversion engine.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_PAUSE = 2'd2
    } ph_state_e;

    // Output bundle of the phase controller.
    typedef struct packed {
        logic run;   // conversion engine may advance
        logic hold;  // engine stalled for realignment
    } phase_out_t;

    // Raise a requested period to the supported minimum.
    function automatic logic [31:0] floor_period(input logic [31:0] req,
                                                 input logic [31:0] low);
        return (req < low) ? low : req;
    endfunction

    // Cycles between the reference strobe and the sync edge at the pin.
    // age  : cycles since the latest strobe when the edge was detected
    // prev : length of the frame that ended at that strobe
    // lat  : synchronizer latency in cycles
    // If the strobe fell inside the latency window, the edge belongs to
    // the frame that just ended, so the offset is measured from its start.
    function automatic logic [31:0] offset_since(input logic [31:0] age,
                                                 input logic [31:0] prev,
                                                 input logic [31:0] lat);
        if (age >= lat)
            return age - lat;
        return prev + age - lat;
    endfunction

endpackage

// File: rtl/frs_sync_edge.sv
module frs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o
);
    // Multi-flop synchronizer followed by one history flop.
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            hist_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            hist_q  <= chain_q[STAGES-1];
        end
    end

    // High for one cycle when the synchronized line goes from 1 to 0.
    assign fall_o = hist_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/frs_frame_timer.sv
module frs_frame_timer #(
    parameter int PERIOD_W   = 16,
    parameter int MIN_PERIOD = 16,
    parameter int DRDY_LOW   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                en_i,
    output logic                fire_o,
    output logic [PERIOD_W-1:0] period_o,
    output logic                drdy_n_o
);
    localparam int LOW_W = $clog2(DRDY_LOW + 1);

    logic [PERIOD_W-1:0] per_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [LOW_W-1:0]    low_q;
    logic [PERIOD_W-1:0] per_next;
    logic                at_end;

    assign per_next = PERIOD_W'(frs_pkg::floor_period(32'(period_i), 32'(MIN_PERIOD)));
    assign at_end   = (cnt_q >= per_q - PERIOD_W'(1));
    // A frame ends only on a cycle in which the engine advances.
    assign fire_o   = en_i && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= per_next;
            cnt_q <= '0;
            low_q <= '0;
        end else if (fire_o) begin
            per_q <= per_next;
            cnt_q <= '0;
            low_q <= LOW_W'(DRDY_LOW);
        end else begin
            if (en_i)
                cnt_q <= cnt_q + PERIOD_W'(1);
            if (low_q != '0)
                low_q <= low_q - LOW_W'(1);
        end
    end

    assign period_o = per_q;
    assign drdy_n_o = (low_q == '0);

endmodule

// File: rtl/frs_phase_ctrl.sv
module frs_phase_ctrl
    import frs_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int AGE_W    = 17,
    parameter int LAT      = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_i,
    input  logic                fire_i,
    input  logic [PERIOD_W-1:0] period_i,
    output phase_out_t          ph_o
);
    logic [AGE_W-1:0] age_q;       // cycles since the latest strobe
    logic [AGE_W-1:0] prev_len_q;  // length of the frame that ended there
    logic [AGE_W-1:0] hold_q;      // offset waiting for the frame end
    logic [AGE_W-1:0] rem_q;       // pause cycles left
    logic [AGE_W-1:0] off_now;
    logic             late_edge;
    ph_state_e        st_q;

    assign off_now   = AGE_W'(offset_since(32'(age_q), 32'(prev_len_q), 32'(LAT)));
    // Strobe fell while the edge was still in the synchronizer.
    assign late_edge = (age_q < AGE_W'(LAT));

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q      <= '0;
            prev_len_q <= AGE_W'(period_i);
            hold_q     <= '0;
            rem_q      <= '0;
            st_q       <= PH_IDLE;
        end else begin
            if (fire_i) begin
                age_q      <= '0;
                prev_len_q <= age_q + AGE_W'(1);
            end else if (age_q != '1) begin
                age_q <= age_q + AGE_W'(1);
            end

            case (st_q)
                PH_IDLE: begin
                    if (fall_i && off_now != '0) begin
                        if (fire_i || late_edge) begin
                            st_q  <= PH_PAUSE;
                            rem_q <= off_now;
                        end else begin
                            st_q   <= PH_ARMED;
                            hold_q <= off_now;
                        end
                    end
                end
                PH_ARMED: begin
                    if (fire_i) begin
                        st_q  <= PH_PAUSE;
                        rem_q <= hold_q;
                    end
                end
                PH_PAUSE: begin
                    if (rem_q == AGE_W'(1))
                        st_q <= PH_IDLE;
                    rem_q <= rem_q - AGE_W'(1);
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    assign ph_o.run  = (st_q != PH_PAUSE);
    assign ph_o.hold = (st_q == PH_PAUSE);

endmodule

// File: rtl/frame_resync.sv
module frame_resync
    import frs_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter int MIN_PERIOD  = 16,
    parameter int DRDY_LOW    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_n_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                drdy_n_o,
    output logic                conv_en_o,
    output logic                pause_o
);
    // Offsets and ages can exceed one period by up to one period.
    localparam int AGE_W = PERIOD_W + 1;
    // Cycles from the pin sample edge to the detection cycle.
    localparam int LAT   = SYNC_STAGES - 1;

    logic                sync_fall;
    logic                fire;
    logic [PERIOD_W-1:0] cur_period;
    phase_out_t          ph;

    frs_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .line_i(sync_n_i),
        .fall_o(sync_fall)
    );

    frs_frame_timer #(
        .PERIOD_W  (PERIOD_W),
        .MIN_PERIOD(MIN_PERIOD),
        .DRDY_LOW  (DRDY_LOW)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .period_i(period_i),
        .en_i    (ph.run),
        .fire_o  (fire),
        .period_o(cur_period),
        .drdy_n_o(drdy_n_o)
    );

    frs_phase_ctrl #(
        .PERIOD_W(PERIOD_W),
        .AGE_W   (AGE_W),
        .LAT     (LAT)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (sync_fall),
        .fire_i  (fire),
        .period_i(cur_period),
        .ph_o    (ph)
    );

    assign conv_en_o = ph.run;
    assign pause_o   = ph.hold;

endmodule

// File: rtl/frame_resync_chk.sv
module frame_resync_chk #(
    parameter int PERIOD_W   = 16,
    parameter int MIN_PERIOD = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                drdy_n,
    input logic                conv_en,
    input logic                pause,
    input logic [PERIOD_W-1:0] cur_period
);
    // R1: outputs idle in the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (drdy_n && conv_en && !pause));

    // R2: a strobe lasts more than one cycle
    a_r2_low_width: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n) |=> !drdy_n);

    // R3: the latched period never drops below the floor
    a_r3_period_floor: assert property (@(posedge clk) disable iff (rst)
        cur_period >= PERIOD_W'(MIN_PERIOD));

    // R10: no strobe while the engine is stalled
    a_r10_no_strobe_in_pause: assert property (@(posedge clk) disable iff (rst)
        (pause && $past(pause)) |-> !$fell(drdy_n));

    // R9: a finished pause is not restarted at once
    a_r9_pause_not_retriggered: assert property (@(posedge clk) disable iff (rst)
        $fell(pause) |=> !pause);

endmodule

bind frame_resync frame_resync_chk #(
    .PERIOD_W  (PERIOD_W),
    .MIN_PERIOD(MIN_PERIOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .drdy_n    (drdy_n_o),
    .conv_en   (conv_en_o),
    .pause     (pause_o),
    .cur_period(cur_period)
);

// File: tb/tb_frame_resync.sv
`timescale 1ns/1ps
module tb_frame_resync;
    localparam int PW = 16;
    localparam int DL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_n = 1'b1;
    logic [PW-1:0] period = 16'd16;
    logic          drdy_n, conv_en, pause;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit prev_drdy = 1'b1;
    int nfall = 0;
    int pacc = 0;
    int fall_t [0:511];
    int pc     [0:511];

    frame_resync #(.PERIOD_W(PW), .MIN_PERIOD(16), .DRDY_LOW(DL), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .sync_n_i(sync_n), .period_i(period),
        .drdy_n_o(drdy_n), .conv_en_o(conv_en), .pause_o(pause)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Records strobe fall edges and pause cycles per frame, between edges.
    always @(posedge clk) begin
        #1;
        if (mon_on && nfall < 511) begin
            if (prev_drdy && !drdy_n) begin
                if (nfall > 0) pc[nfall-1] = pacc;
                pacc = 0;
                fall_t[nfall] = cyc;
                nfall = nfall + 1;
            end
            if (pause) pacc = pacc + 1;
            prev_drdy = drdy_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall(input int idx);
        while (nfall <= idx) @(negedge clk);
    endtask

    task automatic wait_edge(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    // Sync edge sampled o edges after a strobe (o = P: on the next strobe).
    task automatic run_offset(input int o, input int p);
        int base, d, off;
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + o - 1);
        sync_n = 1'b0;
        wait_edge(d + o + 5);
        sync_n = 1'b1;
        wait_fall(base + 3);
        off = (o == p) ? 0 : o;
        chk("R5 frame completes", fall_t[base+1] - fall_t[base], p);
        if (o == p) begin
            chk("R8 zero offset spacing", fall_t[base+2] - fall_t[base+1], p);
            chk("R8 zero offset pause", pc[base+1], 0);
        end else if (o == p - 1) begin
            chk("R11 late edge delay", fall_t[base+2] - fall_t[base+1], p + off);
            chk("R11 late edge pause", pc[base+1], off);
        end else begin
            chk("R6 delayed strobe", fall_t[base+2] - fall_t[base+1], p + off);
            chk("R6 pause length", pc[base+1], off);
        end
        chk("R5 no pause in running frame", pc[base], 0);
        chk("R7 normal spacing after", fall_t[base+3] - fall_t[base+2], p);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        int r, base, d;
        repeat (4) @(negedge clk);
        mon_on = 1'b1;
        chk("R1 drdy in reset", int'(drdy_n), 1);
        chk("R1 en in reset", int'(conv_en), 1);
        rst = 1'b0;
        r = cyc;
        @(negedge clk);
        chk("R1 drdy after reset", int'(drdy_n), 1);
        chk("R1 en after reset", int'(conv_en), 1);
        chk("R1 pause after reset", int'(pause), 0);
        wait_fall(0);
        chk("R1 first strobe", fall_t[0] - r, 16);

        // R2: free running spacing and strobe width
        wait_fall(1);
        wait_edge(fall_t[1] + DL - 1);
        chk("R2 still low", int'(drdy_n), 0);
        @(negedge clk);
        chk("R2 back high", int'(drdy_n), 1);
        wait_fall(3);
        chk("R2 spacing a", fall_t[2] - fall_t[1], 16);
        chk("R2 spacing b", fall_t[3] - fall_t[2], 16);
        chk("R2 no pause", pc[2], 0);

        // Full sweep at P = 16
        for (int o = 1; o <= 16; o++) run_offset(o, 16);

        // R9: second edge while the pause is armed
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 2); sync_n = 1'b0;
        wait_edge(d + 6); sync_n = 1'b1;
        wait_edge(d + 9); sync_n = 1'b0;
        wait_edge(d + 13); sync_n = 1'b1;
        wait_fall(base + 3);
        chk("R9 armed: delay from first edge", fall_t[base+2] - fall_t[base+1], 16 + 3);
        chk("R9 armed: pause length", pc[base+1], 3);
        chk("R9 armed: no second delay", fall_t[base+3] - fall_t[base+2], 16);

        // R9: second edge while the pause runs; line then left low
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 9); sync_n = 1'b0;
        wait_edge(d + 12); sync_n = 1'b1;
        wait_edge(d + 19); sync_n = 1'b0;
        wait_fall(base + 3);
        chk("R9 paused: delay", fall_t[base+2] - fall_t[base+1], 16 + 10);
        chk("R9 paused: pause length", pc[base+1], 10);
        chk("R9 paused: no extra pause", pc[base+2], 0);
        chk("R9 paused: spacing after", fall_t[base+3] - fall_t[base+2], 16);

        // R4: level low, then rising edge, have no effect
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 5); sync_n = 1'b1;
        wait_fall(base + 2);
        chk("R4 spacing with rise", fall_t[base+1] - fall_t[base], 16);
        chk("R4 spacing after rise", fall_t[base+2] - fall_t[base+1], 16);
        chk("R4 no pause", pc[base] + pc[base+1], 0);

        // R3: period latched at the strobe, floor applied
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 2); period = 16'd20;
        wait_fall(base + 2);
        chk("R3 current frame keeps period", fall_t[base+1] - fall_t[base], 16);
        chk("R3 new period used", fall_t[base+2] - fall_t[base+1], 20);
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 2); period = 16'd5;
        wait_fall(base + 2);
        chk("R3 old period kept", fall_t[base+1] - fall_t[base], 20);
        chk("R3 floor applied", fall_t[base+2] - fall_t[base+1], 16);
        base = nfall;
        wait_fall(base);
        d = fall_t[base];
        wait_edge(d + 2); period = 16'd20;
        wait_fall(base + 2);

        // Full sweep at P = 20
        for (int o = 1; o <= 20; o++) run_offset(o, 20);

        finish_up();
    end

endmodule